// File: doc/BRIEF.md
# Byte-Lane Parity Checker and Generator

This block watches a 36-bit bus made of four 9-bit lanes. In each lane the top bit holds parity for the eight bits below it. Every lane that the current bus size uses is checked against the parity type selected by one input. The result is an active-low error flag, computed combinationally from the bus and the control inputs.

The same four parity trees also serve the read path. When a mailbox read is set up with generation enabled, the trees are switched from the incoming bus to the stored read word. Each outgoing lane then carries a freshly computed parity bit in its top position. While the trees are busy generating, they cannot check, so the error flag is held inactive.

On all other cycles the read word passes to the output unchanged.

The control inputs are decoded into one of four named cycle kinds:
- `CYC_IDLE`: chip select high or enable low.
- `CYC_WRITE`: selected with write chosen.
- `CYC_READ`: selected with read chosen, but not a generating mailbox read.
- `CYC_MBX_GEN`: selected, read chosen, mailbox selected and generation high.

Each kind is a pure decode of the present inputs, so every kind can be reached from every other in a single change of inputs.

Top module: `lane_parity_unit`

## Requirements
- R1: Lane i occupies bits [9i+8:9i], with i from 0 to 3. Bit 9i+8 is that lane's parity bit and bits [9i+7:9i] are its data.
- R2: With `odd_sel`=1, a checked lane fails when its nine bits hold an even number of ones.
- R3: With `odd_sel`=0, a checked lane fails when its nine bits hold an odd number of ones.
- R4: The bus size selects which lanes are checked:
  - `bus_size`=00 (long) and 11 (full) check all four lanes.
  - `bus_size`=01 (word) checks lanes 3 and 2 when `end_sel`=0, and lanes 1 and 0 when `end_sel`=1.
  - `bus_size`=10 (byte) checks lane 3 when `end_sel`=0, and lane 0 when `end_sel`=1.
  - Errors in lanes that are not checked have no effect on `err_n`.
- R5: In a `CYC_MBX_GEN` cycle (`cs_n`=0, `en`=1, `wr_sel`=0, `mbx_sel`=1, `gen_en`=1), each lane of `data_out` carries the eight data bits of `rd_data` for that lane. Its top bit is replaced by parity of the type selected by `odd_sel`.
- R6: In a `CYC_MBX_GEN` cycle, `err_n` is 1 whatever `bus_in` holds.
- R7: In every other cycle, `data_out` equals `rd_data`, stored parity bits included.
- R8: `err_n` is combinational. It is low exactly when some checked lane fails, and it follows a change of `bus_in` with no clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| bus_in | input | 36 | Word applied at the bus pins, checked for parity |
| rd_data | input | 36 | Stored word being read out |
| odd_sel | input | 1 | 1 selects odd parity, 0 selects even, for both check and generate |
| bus_size | input | 2 | Active bus size: 00 long, 01 word, 10 byte, 11 full |
| end_sel | input | 1 | 0 uses the upper lanes for narrow sizes, 1 the lower lanes |
| cs_n | input | 1 | Chip select, active low |
| en | input | 1 | Access enable, active high |
| wr_sel | input | 1 | 1 selects write, 0 selects read |
| mbx_sel | input | 1 | Selects the mailbox for the access |
| gen_en | input | 1 | Enables parity generation on mailbox reads |
| data_out | output | 36 | Read word, with regenerated parity when generating |
| err_n | output | 1 | Parity error flag, active low |

## Verification
The checker assumes every input holds a defined 0 or 1 whenever the combinational logic settles. It does not cover unknown values on the control lines. The bench changes all inputs together on the falling clock edge and samples one time unit later, so each check sees a settled, fully known set of inputs. The bench builds each bus word with correct parity and then flips chosen parity bits, so whether a lane is good or bad is known in advance and never depends on the design.

// File: rtl/lane_parity_pkg.sv
package lane_parity_pkg;

    typedef enum logic [1:0] {
        SZ_LONG = 2'b00,
        SZ_WORD = 2'b01,
        SZ_BYTE = 2'b10,
        SZ_FULL = 2'b11
    } bus_size_e;

    typedef enum logic [1:0] {
        CYC_IDLE    = 2'b00,
        CYC_WRITE   = 2'b01,
        CYC_READ    = 2'b10,
        CYC_MBX_GEN = 2'b11
    } cycle_e;

endpackage

// File: rtl/lane_parity_tree.sv
module lane_parity_tree #(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] lane_data,
    input  logic              odd_sel,
    output logic              par_bit
);
    // Bit that makes the lane total match the selected parity type.
    assign par_bit = (^lane_data) ^ odd_sel;
endmodule

// File: rtl/lane_valid_mask.sv
module lane_valid_mask
    import lane_parity_pkg::*;
#(
    parameter int LANES = 4
) (
    input  logic [1:0]       bus_size,
    input  logic             end_sel,
    output logic [LANES-1:0] mask
);
    localparam int HALF = LANES / 2;

    always_comb begin
        mask = '0;
        unique case (bus_size_e'(bus_size))
            SZ_WORD: begin
                for (int i = 0; i < LANES; i++) begin
                    mask[i] = end_sel ? (i < HALF) : (i >= HALF);
                end
            end
            SZ_BYTE: begin
                if (end_sel) mask[0] = 1'b1;
                else         mask[LANES-1] = 1'b1;
            end
            default: mask = '1;
        endcase
    end
endmodule

// File: rtl/lane_parity_unit.sv
module lane_parity_unit
    import lane_parity_pkg::*;
#(
    parameter int LANES  = 4,
    parameter int LANE_W = 9
) (
    input  logic [LANES*LANE_W-1:0] bus_in,
    input  logic [LANES*LANE_W-1:0] rd_data,
    input  logic                    odd_sel,
    input  logic [1:0]              bus_size,
    input  logic                    end_sel,
    input  logic                    cs_n,
    input  logic                    en,
    input  logic                    wr_sel,
    input  logic                    mbx_sel,
    input  logic                    gen_en,
    output logic [LANES*LANE_W-1:0] data_out,
    output logic                    err_n
);
    localparam int DATA_W = LANE_W - 1;
    localparam int BUS_W  = LANES * LANE_W;

    cycle_e           cyc;
    logic             share;
    logic [LANES-1:0] valid;
    logic [LANES-1:0] fail;
    logic [BUS_W-1:0] gen_bus;

    // Cycle decode
    always_comb begin
        if (cs_n || !en)          cyc = CYC_IDLE;
        else if (wr_sel)          cyc = CYC_WRITE;
        else if (mbx_sel && gen_en) cyc = CYC_MBX_GEN;
        else                      cyc = CYC_READ;
    end

    // Tree ownership per cycle kind
    always_comb begin
        unique case (cyc)
            CYC_MBX_GEN: share = 1'b1;
            CYC_IDLE,
            CYC_WRITE,
            CYC_READ:    share = 1'b0;
            default:     share = 1'b0;
        endcase
    end

    lane_valid_mask #(.LANES(LANES)) u_mask (
        .bus_size (bus_size),
        .end_sel  (end_sel),
        .mask     (valid)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [DATA_W-1:0] tree_in;
        logic              tree_par;

        assign tree_in = share ? rd_data[g*LANE_W +: DATA_W]
                               : bus_in[g*LANE_W +: DATA_W];

        lane_parity_tree #(.DATA_W(DATA_W)) u_tree (
            .lane_data (tree_in),
            .odd_sel   (odd_sel),
            .par_bit   (tree_par)
        );

        assign fail[g] = tree_par ^ bus_in[g*LANE_W + DATA_W];
        assign gen_bus[g*LANE_W +: LANE_W] = {tree_par, rd_data[g*LANE_W +: DATA_W]};
    end

    assign data_out = share ? gen_bus : rd_data;
    assign err_n    = share ? 1'b1 : ~|(fail & valid);
endmodule

// File: rtl/lane_parity_unit_chk.sv
module lane_parity_unit_chk #(
    parameter int LANES  = 4,
    parameter int LANE_W = 9
) (
    input logic [LANES*LANE_W-1:0] bus_in,
    input logic [LANES*LANE_W-1:0] rd_data,
    input logic                    odd_sel,
    input logic [1:0]              bus_size,
    input logic                    end_sel,
    input logic                    cs_n,
    input logic                    en,
    input logic                    wr_sel,
    input logic                    mbx_sel,
    input logic                    gen_en,
    input logic [LANES*LANE_W-1:0] data_out,
    input logic                    err_n
);
    logic gen_cyc;
    assign gen_cyc = !cs_n && en && !wr_sel && mbx_sel && gen_en;

    always_comb begin
        if (gen_cyc) begin
            AST_GEN_FLAG_HIGH: assert (err_n == 1'b1);                          // R6
            for (int i = 0; i < LANES; i++) begin
                AST_GEN_LANE_PARITY: assert ((^data_out[i*LANE_W +: LANE_W]) == odd_sel); // R5
                AST_GEN_LANE_DATA: assert (data_out[i*LANE_W +: LANE_W-1]
                                           == rd_data[i*LANE_W +: LANE_W-1]);  // R5
            end
        end else begin
            AST_PASS_THROUGH: assert (data_out == rd_data);                     // R7
            if (bus_size == 2'b10 && end_sel) begin
                AST_BYTE_LOW_ONLY: assert (err_n ==
                    ((^bus_in[LANE_W-1:0]) == odd_sel));                        // R4
            end
        end
    end
endmodule

bind lane_parity_unit lane_parity_unit_chk #(.LANES(LANES), .LANE_W(LANE_W)) u_chk (.*);

// File: tb/lane_parity_unit_tb.sv
module lane_parity_unit_tb;
    logic        clk = 1'b0;
    logic [35:0] bus_in, rd_data, data_out;
    logic        odd_sel, end_sel, cs_n, en, wr_sel, mbx_sel, gen_en, err_n;
    logic [1:0]  bus_size;
    int          checks = 0;
    int          errors = 0;

    always #5 clk = ~clk;

    lane_parity_unit u_dut (
        .bus_in(bus_in), .rd_data(rd_data), .odd_sel(odd_sel), .bus_size(bus_size),
        .end_sel(end_sel), .cs_n(cs_n), .en(en), .wr_sel(wr_sel), .mbx_sel(mbx_sel),
        .gen_en(gen_en), .data_out(data_out), .err_n(err_n)
    );

    typedef struct packed {
        logic [31:0] data;
        logic [3:0]  bad;
        logic        odd;
        logic [1:0]  size;
        logic        endl;
        logic        exp_err_n;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VECS [NV] = '{
        '{32'h12345678, 4'b0000, 1'b1, 2'b00, 1'b0, 1'b1},  // R2 clean
        '{32'h12345678, 4'b0001, 1'b1, 2'b00, 1'b0, 1'b0},  // R2 lane0 bad
        '{32'hA5C3F00F, 4'b0000, 1'b0, 2'b00, 1'b0, 1'b1},  // R3 clean
        '{32'hA5C3F00F, 4'b1000, 1'b0, 2'b00, 1'b0, 1'b0},  // R3 lane3 bad
        '{32'hDEADBEEF, 4'b0011, 1'b1, 2'b01, 1'b0, 1'b1},  // R4 word upper
        '{32'hDEADBEEF, 4'b0011, 1'b1, 2'b01, 1'b1, 1'b0},  // R4 word lower
        '{32'h0F0F0F0F, 4'b0100, 1'b0, 2'b10, 1'b0, 1'b1},  // R4 byte lane3 only
        '{32'h0F0F0F0F, 4'b1000, 1'b0, 2'b10, 1'b0, 1'b0},  // R4 byte lane3 bad
        '{32'hFFFF0000, 4'b1110, 1'b1, 2'b10, 1'b1, 1'b1},  // R4 byte lane0 only
        '{32'hFFFF0000, 4'b0001, 1'b1, 2'b10, 1'b1, 1'b0},  // R4 byte lane0 bad
        '{32'h01020408, 4'b0100, 1'b0, 2'b11, 1'b1, 1'b0},  // R4 full size
        '{32'h80402010, 4'b1111, 1'b1, 2'b00, 1'b0, 1'b0}   // R1 all parity bits
    };

    // Bus word with correct parity per lane, then listed parity bits flipped (R1 layout)
    function automatic logic [35:0] mk_bus(logic [31:0] d, logic [3:0] bad, logic odd);
        logic [35:0] w;
        for (int i = 0; i < 4; i++) begin
            logic [7:0] b;
            b = d[8*i +: 8];
            w[9*i +: 9] = {(^b) ^ odd ^ bad[i], b};
        end
        return w;
    endfunction

    task automatic chk1(string req, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %0b expected %0b", req, act, exp);
        end
    endtask

    task automatic chk36(string req, logic [35:0] act, logic [35:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    initial begin
        #1000000;
        errors++;
        $display("FAIL watchdog: got timeout expected finish");
        $display("  Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        logic [35:0] stored, expect_gen;
        bus_in = '0; rd_data = 36'h123456789; odd_sel = 1'b0; bus_size = 2'b00;
        end_sel = 1'b0; cs_n = 1'b1; en = 1'b0; wr_sel = 1'b0; mbx_sel = 1'b0; gen_en = 1'b0;
        @(negedge clk); #1;
        chk1("R3 idle all-zero bus", err_n, 1'b1);
        chk36("R7 idle pass-through", data_out, 36'h123456789);

        for (int v = 0; v < NV; v++) begin
            @(negedge clk);
            bus_in   = mk_bus(VECS[v].data, VECS[v].bad, VECS[v].odd);
            odd_sel  = VECS[v].odd;
            bus_size = VECS[v].size;
            end_sel  = VECS[v].endl;
            rd_data  = {4'h5, VECS[v].data};
            #1;
            chk1("R4 vector err_n", err_n, VECS[v].exp_err_n);
            chk36("R7 vector pass-through", data_out, {4'h5, VECS[v].data});
        end

        // R5 / R6: mailbox read with generation, stored parity wrong, bus lanes bad
        stored = 36'h1_FF_80_7F_00;
        for (int o = 0; o < 2; o++) begin
            @(negedge clk);
            odd_sel = o[0]; bus_size = 2'b00;
            bus_in = mk_bus(32'h11223344, 4'b1111, o[0]);
            rd_data = stored;
            cs_n = 1'b0; en = 1'b1; wr_sel = 1'b0; mbx_sel = 1'b1; gen_en = 1'b1;
            for (int i = 0; i < 4; i++)
                expect_gen[9*i +: 9] = {(^stored[9*i +: 8]) ^ o[0], stored[9*i +: 8]};
            #1;
            chk1("R6 flag forced high", err_n, 1'b1);
            chk36("R5 generated parity", data_out, expect_gen);
        end

        // R7: generation off, stored parity kept; flag returns
        @(negedge clk); gen_en = 1'b0; #1;
        chk36("R7 gen off pass-through", data_out, stored);
        chk1("R8 flag after gen off", err_n, 1'b0);
        @(negedge clk); gen_en = 1'b1; mbx_sel = 1'b0; #1;
        chk36("R7 non-mailbox read", data_out, stored);
        @(negedge clk); mbx_sel = 1'b1; wr_sel = 1'b1; #1;
        chk36("R7 write cycle", data_out, stored);
        chk1("R6 write not forced", err_n, 1'b0);

        // R8: combinational response, mid-cycle change
        @(negedge clk);
        cs_n = 1'b1; odd_sel = 1'b1;
        bus_in = mk_bus(32'hCAFEF00D, 4'b0000, 1'b1); #1;
        chk1("R8 clean", err_n, 1'b1);
        #2; bus_in[26] = ~bus_in[26]; #1;
        chk1("R8 R1 lane2 parity bit flip", err_n, 1'b0);
        #1; bus_in[26] = ~bus_in[26]; bus_in[3] = ~bus_in[3]; #1;
        chk1("R1 lane0 data bit flip", err_n, 1'b0);

        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule